// File: doc/BRIEF.md
# Floating-Point Control Register Decoder

This block holds the 32-bit floating-point control image that software writes through a 64-bit data word. It also drives a set of decoded side-band signals that an arithmetic unit consumes: a rounding-mode code, one trap-enable bit per exception class, a flag that flushes denormal inputs, and a flag that flushes underflowing results to zero.

The image sits in the upper half of the 64-bit word. A write keeps only that half, exactly as given. A read returns the image in the upper half with zeros below it. The decoded outputs are registered. They are loaded from the written value by the same write strobe, so they change on the clock edge that stores the image.

The disable bits in the image are active-high. The block turns them into active-high trap enables. Result flushing needs two image bits set together.

Top module: `fpctl_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the image. After that edge `rd_data` is zero, `round_mode` is 2'b01 (toward zero), `trap_en` is 5'b11111, and both flush flags are 0.
- R2: A clock edge with `wr_en` high stores `wr_data[63:32]` without change. From the next sample on, `rd_data[63:32]` equals that value.
- R3: `rd_data[31:0]` is always zero, and `wr_data[31:0]` has no effect on any output.
- R4: While `wr_en` is low, `rd_data` and all decoded outputs keep their values.
- R5: The rounding field sits at image bits 27:26 (word bits 59:58). Field value 0 gives `round_mode` 1 (toward zero). Field value 1 gives 2 (down). Field value 2 gives 0 (nearest-even). Field value 3 gives 3 (up).
- R6: `trap_en` is indexed [0] invalid, [1] divide-by-zero, [2] overflow, [3] underflow, [4] inexact. Each bit is the complement of the matching disable bit at image bits 17, 18, 19, 29 and 30 (word bits 49, 50, 51, 61, 62).
- R7: `flush_denorm_in` equals image bit 16 (word bit 48).
- R8: `flush_result` is 1 only when the underflow-disable bit (image bit 29) and the underflow-to-zero bit (image bit 28) are both 1.
- R9: Decoded outputs keep their old values until the clock edge that samples `wr_en` high. They take the new values right after that edge, together with the image.
- R10: The status bits at image bits 25:20, and the other unassigned bits, are stored and read back. They do not change any decoded output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write word; image in bits 63:32 |
| rd_data | output | 64 | Stored image in bits 63:32, zeros below |
| round_mode | output | 2 | 0 nearest-even, 1 toward zero, 2 down, 3 up |
| trap_en | output | 5 | Per-class trap enables |
| flush_denorm_in | output | 1 | Flush denormal operands |
| flush_result | output | 1 | Flush underflowing results to zero |

## Verification
The assertions assume `rst` is held high across the first clock edge. They also assume `wr_en` and `wr_data` carry known values at every rising edge, so that the stored image and the decoded registers always start from the same value. The bench asserts reset from time zero. It changes the inputs only on falling edges, and it never leaves the write inputs undriven. Every written word therefore reaches the image and the decoded outputs on the same edge.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;

  localparam int unsigned WORD_W = 64;
  localparam int unsigned IMG_W  = 32;
  localparam int unsigned N_EXC  = 5;
  localparam int unsigned RM_W   = 2;

  // Image bit positions (software-visible layout)
  localparam int unsigned P_DENORM_IN = 16;
  localparam int unsigned P_UF_ZERO   = 28;
  localparam int unsigned P_RM_LO     = 26;

  // Disable bit per class: invalid, div-zero, overflow, underflow, inexact
  localparam int unsigned DIS_POS [N_EXC] = '{17, 18, 19, 29, 30};
  localparam int unsigned IDX_UNDERFLOW = 3;

  // Encoded rounding modes delivered to the arithmetic unit
  typedef enum logic [RM_W-1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_DOWN    = 2'd2,
    RM_UP      = 2'd3
  } rmode_e;

  typedef struct packed {
    rmode_e           rmode;
    logic [N_EXC-1:0] traps;
    logic             dnz;
    logic             ftz;
  } side_t;

endpackage

// File: rtl/fpctl_image_reg.sv
module fpctl_image_reg #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned IMG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [IMG_W-1:0]  img,
  output logic [WORD_W-1:0] rd_data
);
  localparam int unsigned IMG_LSB = WORD_W - IMG_W;

  logic [IMG_W-1:0] img_q;

  always_ff @(posedge clk) begin
    if (rst)        img_q <= '0;
    else if (wr_en) img_q <= wr_data[WORD_W-1:IMG_LSB];
  end

  assign img     = img_q;
  assign rd_data = {img_q, {IMG_LSB{1'b0}}};
endmodule

// File: rtl/fpctl_round_map.sv
module fpctl_round_map
  import fpctl_pkg::*;
(
  input  logic [RM_W-1:0] field,
  output rmode_e          mode
);
  // Field: 0 chopped, 1 minus, 2 normal, 3 plus
  always_comb begin
    unique case (field)
      2'd0:    mode = RM_ZERO;
      2'd1:    mode = RM_DOWN;
      2'd2:    mode = RM_NEAREST;
      default: mode = RM_UP;
    endcase
  end
endmodule

// File: rtl/fpctl_side_decode.sv
module fpctl_side_decode
  import fpctl_pkg::*;
#(
  parameter int unsigned IMG_W = 32
) (
  input  logic [IMG_W-1:0] img,
  output side_t            side
);
  rmode_e           rm;
  logic [N_EXC-1:0] tr;

  fpctl_round_map u_rmap (
    .field (img[P_RM_LO +: RM_W]),
    .mode  (rm)
  );

  for (genvar g = 0; g < N_EXC; g++) begin : g_trap
    assign tr[g] = ~img[DIS_POS[g]];
  end

  always_comb begin
    side.rmode = rm;
    side.traps = tr;
    side.dnz   = img[P_DENORM_IN];
    side.ftz   = img[DIS_POS[IDX_UNDERFLOW]] & img[P_UF_ZERO];
  end
endmodule

// File: rtl/fpctl_decoder.sv
module fpctl_decoder
  import fpctl_pkg::*;
#(
  parameter int unsigned P_WORD_W = WORD_W,
  parameter int unsigned P_IMG_W  = IMG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [P_WORD_W-1:0] wr_data,
  output logic [P_WORD_W-1:0] rd_data,
  output logic [RM_W-1:0]     round_mode,
  output logic [N_EXC-1:0]    trap_en,
  output logic                flush_denorm_in,
  output logic                flush_result
);
  localparam int unsigned IMG_LSB = P_WORD_W - P_IMG_W;
  localparam side_t SIDE_RST = '{rmode: RM_ZERO, traps: {N_EXC{1'b1}},
                                 dnz: 1'b0, ftz: 1'b0};

  logic [P_IMG_W-1:0] img;
  side_t              side_nxt, side_q;

  fpctl_image_reg #(.WORD_W(P_WORD_W), .IMG_W(P_IMG_W)) u_img (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .img     (img),
    .rd_data (rd_data)
  );

  // Decode the incoming image so the side-band updates with the store
  fpctl_side_decode #(.IMG_W(P_IMG_W)) u_dec (
    .img  (wr_data[P_WORD_W-1:IMG_LSB]),
    .side (side_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)        side_q <= SIDE_RST;
    else if (wr_en) side_q <= side_nxt;
  end

  assign round_mode      = side_q.rmode;
  assign trap_en         = side_q.traps;
  assign flush_denorm_in = side_q.dnz;
  assign flush_result    = side_q.ftz;

  logic unused_img;
  assign unused_img = ^img;
endmodule

// File: rtl/fpctl_decoder_chk.sv
module fpctl_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [63:0] wr_data,
  input logic [63:0] rd_data,
  input logic [1:0]  round_mode,
  input logic [4:0]  trap_en,
  input logic        flush_denorm_in,
  input logic        flush_result
);
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data[63:32] == $past(wr_data[63:32]));

  a_r3_low_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[31:0] == 32'h0);

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data) && $stable(round_mode) && $stable(trap_en)
               && $stable(flush_denorm_in) && $stable(flush_result));

  a_r6_trap_uf: assert property (@(posedge clk) disable iff (rst)
    trap_en[3] == !rd_data[61]);

  a_r7_dnz: assert property (@(posedge clk) disable iff (rst)
    flush_denorm_in == rd_data[48]);

  a_r8_ftz: assert property (@(posedge clk) disable iff (rst)
    flush_result == (rd_data[61] && rd_data[60]));
endmodule

bind fpctl_decoder fpctl_decoder_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .wr_en           (wr_en),
  .wr_data         (wr_data),
  .rd_data         (rd_data),
  .round_mode      (round_mode),
  .trap_en         (trap_en),
  .flush_denorm_in (flush_denorm_in),
  .flush_result    (flush_result)
);

// File: tb/tb_fpctl_decoder.sv
module tb_fpctl_decoder;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [1:0]  round_mode;
  logic [4:0]  trap_en;
  logic        flush_denorm_in, flush_result;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpctl_decoder dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] m_round(input logic [31:0] im);
    case (im[27:26])
      2'd0: return 2'd1;
      2'd1: return 2'd2;
      2'd2: return 2'd0;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [4:0] m_traps(input logic [31:0] im);
    return ~{im[30], im[29], im[19], im[18], im[17]};
  endfunction

  task automatic check_all(input string req, input logic [31:0] im);
    chk(req, rd_data, {im, 32'h0});
    chk(req, {62'h0, round_mode}, {62'h0, m_round(im)});
    chk(req, {59'h0, trap_en}, {59'h0, m_traps(im)});
    chk(req, {63'h0, flush_denorm_in}, {63'h0, im[16]});
    chk(req, {63'h0, flush_result}, {63'h0, im[29] & im[28]});
  endtask

  task automatic write(input logic [63:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 64'hDEAD_BEEF_DEAD_BEEF;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 rd", rd_data, 64'h0);
    chk("R1 rm", {62'h0, round_mode}, 64'd1);
    chk("R1 trap", {59'h0, trap_en}, 64'h1f);
    chk("R1 dnz", {63'h0, flush_denorm_in}, 64'h0);
    chk("R1 ftz", {63'h0, flush_result}, 64'h0);
  endtask

  task automatic t_round;
    for (int f = 0; f < 4; f++) begin
      logic [31:0] im = 32'(f) << 26;
      write({im, 32'h0});
      check_all("R5 round", im);
    end
  endtask

  task automatic t_traps;
    int pos [5] = '{17, 18, 19, 29, 30};
    for (int i = 0; i < 5; i++) begin
      logic [31:0] im = 32'h1 << pos[i];
      write({im, 32'h0});
      check_all("R6 trap", im);
    end
    write({32'h7FFF_FFFF, 32'h0});
    check_all("R6 all", 32'h7FFF_FFFF);
  endtask

  task automatic t_flush;
    write({32'h0001_0000, 32'h0});
    check_all("R7 dnz", 32'h0001_0000);
    write({32'h1000_0000, 32'h0});
    check_all("R8 uz only", 32'h1000_0000);
    write({32'h2000_0000, 32'h0});
    check_all("R8 ufd only", 32'h2000_0000);
    write({32'h3000_0000, 32'h0});
    check_all("R8 both", 32'h3000_0000);
  endtask

  task automatic t_store_raw;
    write({32'hA5C3_0F69, 32'hFFFF_FFFF});
    check_all("R2 R3 raw", 32'hA5C3_0F69);
    write({32'h03F0_0000, 32'h1234_5678});
    check_all("R10 status", 32'h03F0_0000);
  endtask

  task automatic t_hold;
    write({32'h2C01_0000, 32'h0});
    repeat (3) begin
      @(negedge clk); wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
    end
    @(negedge clk);
    check_all("R4 hold", 32'h2C01_0000);
  endtask

  task automatic t_latency;
    write(64'h0);
    @(negedge clk); wr_en = 1'b1; wr_data = {32'h7401_0000, 32'h0};
    #1;
    check_all("R9 before edge", 32'h0);
    @(negedge clk); wr_en = 1'b0;
    check_all("R9 after edge", 32'h7401_0000);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_round();
    t_traps();
    t_flush();
    t_store_raw();
    t_hold();
    t_latency();
    write({32'hFFFF_FFFF, 32'h0});
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule